// File: doc/BRIEF.md
# Flash Memory Controller with Separate Program and Erase Permissions

This block sits between a single 32-bit access port and a word-addressed NOR-style flash array, which is kept here as on-chip registers, together with a small array of user configuration words. Each access selects one of four regions. The control region holds a configuration register, a ready status, two page-erase address registers, a full-erase command and a user-area erase command. The flash region takes data writes and reads of the array. The user region is a plain read/write word array. The fourth region is unmapped.

The configuration register has two separate permission bits. One permits programming and the other permits erasing. Programming can only clear bits: the stored word becomes the old word ANDed with the written data. Erases are run by a sequencer that fills one word with all-ones per clock. While an erase runs, the ready status reads busy, and every write is held off with a stall. Reads still complete one cycle after they are requested. A rejected operation gives a one-cycle error pulse.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the configuration register reads 0, every user-area word reads 32'hFFFFFFFF, and the ready status reads 1.
- R2: A write to control index 1 keeps only bits [1:0] (bit 0 = program enable, bit 1 = erase enable) and drops all other bits. A read of index 1 returns the stored value.
- R3: With program enable set, a flash-region write to word a makes word a equal to its old value AND the written data.
- R4: With program enable clear, a flash-region write leaves the array unchanged, and op_err is 1 in the cycle after the write is accepted.
- R5: With erase enable set, a write to control index 2 or 3 treats the data as a byte address and clears its low log2(PAGE_WORDS*4) bits. The PAGE_WORDS flash words from that base are then set to all-ones, one word per cycle, taking PAGE_WORDS cycles.
- R6: A page erase whose base byte address exceeds (FLASH_WORDS-PAGE_WORDS)*4 changes nothing, raises no error and never reads busy.
- R7: A page erase written while erase enable is clear changes nothing and pulses op_err.
- R8: A write to control index 4 acts only when the data equals 1. It then needs erase enable: without it op_err pulses, and with it every flash word and every user word becomes all-ones over FLASH_WORDS cycles. Any other data is ignored without error.
- R9: A write of 1 to control index 5 sets every user word to all-ones over USR_WORDS cycles, whatever the permission bits are. Any other data is ignored.
- R10: Control index 0 reads 1 when no erase runs and 0 while one runs. Reads in every region are accepted during an erase, and bus_rvalid/bus_rdata follow one cycle after the request.
- R11: While an erase runs, a write request sees bus_stall high and has no effect. It takes effect in the first cycle after the erase ends.
- R12: Reads of control indices other than 0 and 1, and of region 3, return 0. Writes to control index 0 or any index above 5, and any write to region 3, pulse op_err and change nothing.
- R13: A user-region write stores the data unchanged at the word given by the low log2(USR_WORDS) address bits, and it needs no permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Region: 0 control, 1 flash, 2 user, 3 unmapped |
| bus_addr | input | AW | Word index within the region |
| bus_wdata | input | 32 | Write data |
| bus_stall | output | 1 | Write held off because an erase is running |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read request |
| bus_rdata | output | 32 | Read data |
| op_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The overlap that matters is a read arriving in the same cycle as the erase sequencer's fill of a word. The read must return the value that word held before that edge, and a register read must report busy. The bench starts a full erase and then, during the sweep, reads the ready status, a flash word and a user word, and puts a write on the port that has to stall. A behavioural model applies each cycle's erase step and each accepted access in order. On every clock it predicts rvalid, rdata, op_err and bus_stall, so a read issued during the sweep is judged against the model's pre-edge array contents.

// File: rtl/nvm_pkg.sv
// Shared definitions for the flash controller: region codes, control
// register indices, configuration bit positions and erase kinds.
package nvm_pkg;

    typedef enum logic [1:0] {
        RG_CTRL  = 2'd0,
        RG_FLASH = 2'd1,
        RG_USER  = 2'd2,
        RG_NONE  = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        EK_PAGE = 2'd0,
        EK_ALL  = 2'd1,
        EK_USER = 2'd2
    } erase_kind_e;

    localparam int IDX_READY = 0;
    localparam int IDX_CFG   = 1;
    localparam int IDX_PGE_A = 2;
    localparam int IDX_PGE_B = 3;
    localparam int IDX_ERALL = 4;
    localparam int IDX_ERUSR = 5;

    localparam int CFG_W   = 2;
    localparam int CFG_PGM = 0;
    localparam int CFG_ERS = 1;

    localparam logic [31:0] ERASE_KEY = 32'd1;

endpackage

// File: rtl/nvm_regs.sv
// Register decode and permission checks.
// Decides, for the access presented this cycle, whether it is accepted,
// whether it programs flash, writes the user area or starts an erase, and
// whether it is rejected. Holds the configuration register and the error
// pulse. Assumes one access per cycle, with writes held off while busy.
module nvm_regs
    import nvm_pkg::*;
#(
    parameter int FLASH_WORDS = 1024,
    parameter int PAGE_WORDS  = 256,
    parameter int AW          = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    output logic              fl_we,
    output logic              usr_we,
    output logic              start,
    output erase_kind_e       start_kind,
    output logic [AW-1:0]     start_base,
    output logic [31:0]       ctrl_rdata,
    output logic              err
);
    localparam logic [31:0] PAGE_BYTES = 32'(PAGE_WORDS * 4);
    localparam logic [31:0] LAST_BASE  = 32'((FLASH_WORDS - PAGE_WORDS) * 4);

    logic [CFG_W-1:0] cfg_q;
    logic             err_q;
    logic             acc;
    logic             wr;
    logic             reject;
    logic             cfg_we;
    logic [31:0]      pg_byte;
    logic             pg_ok;
    region_e          rg;

    assign acc     = req & ~(busy & we);
    assign wr      = acc & we;
    assign rg      = region_e'(sel);
    assign pg_byte = wdata & ~(PAGE_BYTES - 32'd1);
    assign pg_ok   = (pg_byte <= LAST_BASE);

    // Classify the accepted write: program, user store, erase start or reject.
    always_comb begin
        fl_we      = 1'b0;
        usr_we     = 1'b0;
        start      = 1'b0;
        start_kind = EK_PAGE;
        start_base = AW'(pg_byte >> 2);
        reject     = 1'b0;
        cfg_we     = 1'b0;
        if (wr) begin
            case (rg)
                RG_CTRL: begin
                    if (addr == AW'(IDX_CFG)) begin
                        cfg_we = 1'b1;
                    end else if (addr == AW'(IDX_PGE_A) || addr == AW'(IDX_PGE_B)) begin
                        if (!cfg_q[CFG_ERS]) reject = 1'b1;
                        else if (pg_ok)      start  = 1'b1;
                    end else if (addr == AW'(IDX_ERALL)) begin
                        if (wdata == ERASE_KEY) begin
                            if (cfg_q[CFG_ERS]) begin
                                start      = 1'b1;
                                start_kind = EK_ALL;
                            end else begin
                                reject = 1'b1;
                            end
                        end
                    end else if (addr == AW'(IDX_ERUSR)) begin
                        if (wdata == ERASE_KEY) begin
                            start      = 1'b1;
                            start_kind = EK_USER;
                        end
                    end else begin
                        reject = 1'b1;
                    end
                end
                RG_FLASH: begin
                    if (cfg_q[CFG_PGM]) fl_we  = 1'b1;
                    else                reject = 1'b1;
                end
                RG_USER:  usr_we = 1'b1;
                default:  reject = 1'b1;
            endcase
        end
    end

    // Configuration register and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (cfg_we) cfg_q <= wdata[CFG_W-1:0];
            err_q <= reject;
        end
    end

    // Read value of the control region.
    always_comb begin
        if (addr == AW'(IDX_READY))    ctrl_rdata = {31'd0, ~busy};
        else if (addr == AW'(IDX_CFG)) ctrl_rdata = 32'(cfg_q);
        else                           ctrl_rdata = 32'd0;
    end

    assign err = err_q;

    AST_ERASE_NEEDS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_kind != EK_USER) |-> cfg_q[CFG_ERS]);             // R7
    AST_PROGRAM_NEEDS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> cfg_q[CFG_PGM]);                                        // R4
    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(req && we && !busy));                             // R12

endmodule

// File: rtl/nvm_erase_seq.sv
// Erase sequencer. On a start it fills one word per clock with all-ones:
// a page of flash, the whole flash plus the user area in parallel, or the
// user area alone. It drives busy until the last word is written.
// Assumes start is raised only while busy is low.
module nvm_erase_seq
    import nvm_pkg::*;
#(
    parameter int FLASH_WORDS = 1024,
    parameter int PAGE_WORDS  = 256,
    parameter int USR_WORDS   = 64,
    parameter int AW          = 10,
    parameter int UAW         = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  erase_kind_e       kind,
    input  logic [AW-1:0]     base,
    output logic              busy,
    output logic              er_fl_we,
    output logic [AW-1:0]     er_fl_addr,
    output logic              er_usr_we,
    output logic [UAW-1:0]    er_usr_addr
);
    localparam int CW = $clog2(FLASH_WORDS + 1);

    logic           busy_q;
    erase_kind_e    kind_q;
    logic [AW-1:0]  base_q;
    logic [CW-1:0]  ptr_q;
    logic [CW-1:0]  last_q;
    logic [CW-1:0]  len;

    // Word count for each kind of erase.
    always_comb begin
        case (kind)
            EK_ALL:  len = CW'(FLASH_WORDS);
            EK_USER: len = CW'(USR_WORDS);
            default: len = CW'(PAGE_WORDS);
        endcase
    end

    // Sweep pointer and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            kind_q <= EK_PAGE;
            base_q <= '0;
            ptr_q  <= '0;
            last_q <= '0;
        end else if (busy_q) begin
            if (ptr_q == last_q - CW'(1)) busy_q <= 1'b0;
            ptr_q <= ptr_q + CW'(1);
        end else if (start) begin
            busy_q <= 1'b1;
            kind_q <= kind;
            base_q <= (kind == EK_PAGE) ? base : '0;
            ptr_q  <= '0;
            last_q <= len;
        end
    end

    assign busy        = busy_q;
    assign er_fl_we    = busy_q && (kind_q != EK_USER);
    assign er_fl_addr  = base_q + AW'(ptr_q);
    assign er_usr_we   = busy_q && ((kind_q == EK_USER) ||
                         (kind_q == EK_ALL && ptr_q < CW'(USR_WORDS)));
    assign er_usr_addr = UAW'(ptr_q);

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (ptr_q < last_q));                                     // R5
    AST_SWEEP_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(ptr_q) == $past(last_q) - CW'(1)));      // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !start);                                               // R11

endmodule

// File: rtl/nvm_store.sv
// Storage for the flash array and the user area. A program write ANDs
// into the stored word, and an erase write forces all-ones. Reads are
// combinational. The user area resets to all-ones. The flash array has
// no reset. Assumes erase and access writes never land in the same cycle.
module nvm_store #(
    parameter int FLASH_WORDS = 1024,
    parameter int USR_WORDS   = 64,
    parameter int AW          = 10,
    parameter int UAW         = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_we,
    input  logic [AW-1:0]     fl_addr,
    input  logic [31:0]       wdata,
    input  logic              usr_we,
    input  logic [UAW-1:0]    usr_addr,
    input  logic              er_fl_we,
    input  logic [AW-1:0]     er_fl_addr,
    input  logic              er_usr_we,
    input  logic [UAW-1:0]    er_usr_addr,
    output logic [31:0]       fl_rword,
    output logic [31:0]       usr_rword
);
    logic [31:0] fl_mem  [FLASH_WORDS];
    logic [31:0] usr_mem [USR_WORDS];

    // Flash array: erase fill or bit-clearing program.
    always_ff @(posedge clk) begin
        if (er_fl_we)   fl_mem[er_fl_addr] <= '1;
        else if (fl_we) fl_mem[fl_addr]    <= fl_mem[fl_addr] & wdata;
    end

    // User area: reset fill, erase fill or plain store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < USR_WORDS; i++) usr_mem[i] <= '1;
        end else if (er_usr_we) begin
            usr_mem[er_usr_addr] <= '1;
        end else if (usr_we) begin
            usr_mem[usr_addr] <= wdata;
        end
    end

    assign fl_rword  = fl_mem[fl_addr];
    assign usr_rword = usr_mem[usr_addr];

    AST_PROGRAM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |=> ((fl_mem[$past(fl_addr)] & ~$past(wdata)) == 32'd0));   // R3
    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && er_fl_we) && !(usr_we && er_usr_we));                  // R11

endmodule

// File: rtl/nvm_ctrl.sv
// Flash controller top. Joins the register decode, the erase sequencer
// and the storage, registers read data one cycle after the request and
// stalls writes while an erase runs.
// Assumes USR_WORDS <= FLASH_WORDS, and that PAGE_WORDS divides
// FLASH_WORDS and is a power of two.
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int FLASH_WORDS = 1024,
    parameter int PAGE_WORDS  = 256,
    parameter int USR_WORDS   = 64,
    parameter int AW          = $clog2(FLASH_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic          bus_stall,
    output logic          bus_rvalid,
    output logic [31:0]   bus_rdata,
    output logic          op_err
);
    localparam int UAW = $clog2(USR_WORDS);

    logic              busy;
    logic              fl_we;
    logic              usr_we;
    logic              start;
    erase_kind_e       start_kind;
    logic [AW-1:0]     start_base;
    logic [31:0]       ctrl_rdata;
    logic              er_fl_we;
    logic [AW-1:0]     er_fl_addr;
    logic              er_usr_we;
    logic [UAW-1:0]    er_usr_addr;
    logic [31:0]       fl_rword;
    logic [31:0]       usr_rword;
    logic              rvalid_q;
    logic [31:0]       rdata_q;
    logic [31:0]       rd_mux;

    nvm_regs #(
        .FLASH_WORDS(FLASH_WORDS), .PAGE_WORDS(PAGE_WORDS), .AW(AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .sel(bus_sel),
        .addr(bus_addr), .wdata(bus_wdata), .busy(busy),
        .fl_we(fl_we), .usr_we(usr_we), .start(start),
        .start_kind(start_kind), .start_base(start_base),
        .ctrl_rdata(ctrl_rdata), .err(op_err)
    );

    nvm_erase_seq #(
        .FLASH_WORDS(FLASH_WORDS), .PAGE_WORDS(PAGE_WORDS),
        .USR_WORDS(USR_WORDS), .AW(AW), .UAW(UAW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(start_kind),
        .base(start_base), .busy(busy),
        .er_fl_we(er_fl_we), .er_fl_addr(er_fl_addr),
        .er_usr_we(er_usr_we), .er_usr_addr(er_usr_addr)
    );

    nvm_store #(
        .FLASH_WORDS(FLASH_WORDS), .USR_WORDS(USR_WORDS), .AW(AW), .UAW(UAW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .fl_we(fl_we), .fl_addr(bus_addr), .wdata(bus_wdata),
        .usr_we(usr_we), .usr_addr(bus_addr[UAW-1:0]),
        .er_fl_we(er_fl_we), .er_fl_addr(er_fl_addr),
        .er_usr_we(er_usr_we), .er_usr_addr(er_usr_addr),
        .fl_rword(fl_rword), .usr_rword(usr_rword)
    );

    // Select read data by region.
    always_comb begin
        case (region_e'(bus_sel))
            RG_CTRL:  rd_mux = ctrl_rdata;
            RG_FLASH: rd_mux = fl_rword;
            RG_USER:  rd_mux = usr_rword;
            default:  rd_mux = 32'd0;
        endcase
    end

    // Register read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= bus_req & ~bus_we;
            if (bus_req && !bus_we) rdata_q <= rd_mux;
        end
    end

    assign bus_stall  = busy & bus_req & bus_we;
    assign bus_rvalid = rvalid_q;
    assign bus_rdata  = rdata_q;

    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(fl_we || usr_we || start));                            // R11
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);                             // R10

endmodule

// File: tb/sim_nvm_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_ctrl;
    localparam int FW  = 1024;
    localparam int PW  = 256;
    localparam int UW  = 64;
    localparam int AW  = $clog2(FW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_sel = 2'd0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_stall;
    logic          bus_rvalid;
    logic [31:0]   bus_rdata;
    logic          op_err;

    always #4 clk = ~clk;

    nvm_ctrl #(.FLASH_WORDS(FW), .PAGE_WORDS(PW), .USR_WORDS(UW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_stall(bus_stall), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .op_err(op_err)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";

    // Reference model state
    bit [31:0] mf [FW];
    bit [31:0] mu [UW];
    bit [31:0] m_cfg;
    bit        m_busy;
    int        m_ptr, m_last, m_kind, m_base;
    bit        m_acc;
    bit        e_rvalid, e_err;
    bit [31:0] e_rdata;

    initial begin
        for (int i = 0; i < FW; i++) mf[i] = '1;
    end

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Cycle model: read from pre-edge state, erase step, accepted write.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_busy = 0; m_acc = 0; e_rvalid = 0; e_err = 0; e_rdata = 0;
            for (int i = 0; i < UW; i++) mu[i] = '1;
        end else begin
            bit        bp;
            bit [31:0] rv;
            int        a;
            bit [31:0] pb;
            bp = m_busy;
            a  = int'(bus_addr);
            rv = 0;
            case (bus_sel)
                2'd0: rv = (a == 0) ? (bp ? 32'd0 : 32'd1) : (a == 1) ? m_cfg : 32'd0;
                2'd1: rv = mf[a];
                2'd2: rv = mu[a % UW];
                default: rv = 0;
            endcase
            e_err = 0;
            m_acc = bus_req && !(bp && bus_we);
            if (bp) begin
                if (m_kind != 2) mf[m_base + m_ptr] = '1;
                if (m_kind == 2 || (m_kind == 1 && m_ptr < UW)) mu[m_ptr] = '1;
                m_ptr++;
                if (m_ptr == m_last) m_busy = 0;
            end
            if (m_acc && bus_we) begin
                case (bus_sel)
                    2'd0: begin
                        if (a == 1) m_cfg = bus_wdata & 32'd3;
                        else if (a == 2 || a == 3) begin
                            if (!m_cfg[1]) e_err = 1;
                            else begin
                                pb = bus_wdata & ~(32'(PW * 4) - 1);
                                if (pb <= 32'((FW - PW) * 4)) begin
                                    m_busy = 1; m_ptr = 0; m_kind = 0;
                                    m_base = int'(pb / 4); m_last = PW;
                                end
                            end
                        end else if (a == 4) begin
                            if (bus_wdata == 1) begin
                                if (m_cfg[1]) begin
                                    m_busy = 1; m_ptr = 0; m_kind = 1; m_base = 0; m_last = FW;
                                end else e_err = 1;
                            end
                        end else if (a == 5) begin
                            if (bus_wdata == 1) begin
                                m_busy = 1; m_ptr = 0; m_kind = 2; m_base = 0; m_last = UW;
                            end
                        end else e_err = 1;
                    end
                    2'd1: if (m_cfg[0]) mf[a] = mf[a] & bus_wdata; else e_err = 1;
                    2'd2: mu[a % UW] = bus_wdata;
                    default: e_err = 1;
                endcase
            end
            e_rvalid = bus_req && !bus_we;
            if (e_rvalid) e_rdata = rv;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(bus_rvalid == e_rvalid, "rvalid", 32'(bus_rvalid), 32'(e_rvalid));
            check(op_err == e_err, "op_err", 32'(op_err), 32'(e_err));
            check(bus_stall == (m_busy && bus_req && bus_we), "stall",
                  32'(bus_stall), 32'(m_busy && bus_req && bus_we));
            if (e_rvalid) check(bus_rdata == e_rdata, "rdata", bus_rdata, e_rdata);
        end
    end

    task automatic op(input logic [1:0] s, input bit w, input int a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_req = 1; bus_we = w; bus_sel = s; bus_addr = AW'(a); bus_wdata = d;
        do begin @(posedge clk); #1; end while (!m_acc);
        @(negedge clk); #1;
        bus_req = 0; bus_we = 0;
    endtask

    task automatic rd_lit(input logic [1:0] s, input int a, input logic [31:0] exp);
        op(s, 0, a, 0);
        check(bus_rdata == exp, "read literal", bus_rdata, exp);
    endtask

    task automatic wait_idle();
        while (m_busy) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        cur_req = "R1";
        rd_lit(2'd0, 0, 32'd1);
        rd_lit(2'd0, 1, 32'd0);
        rd_lit(2'd2, 0, 32'hFFFFFFFF);
        rd_lit(2'd2, UW - 1, 32'hFFFFFFFF);
        // R2 configuration mask
        cur_req = "R2";
        op(2'd0, 1, 1, 32'hFFFF_FFFC);
        rd_lit(2'd0, 1, 32'd0);
        op(2'd0, 1, 1, 32'hFFFF_FFFE);
        rd_lit(2'd0, 1, 32'd2);
        // R8 full erase with concurrent reads and a stalled write
        cur_req = "R8";
        op(2'd0, 1, 4, 32'd1);
        cur_req = "R10";
        rd_lit(2'd0, 0, 32'd0);
        repeat (20) @(negedge clk);
        op(2'd1, 0, 3, 0);
        op(2'd2, 0, 7, 0);
        cur_req = "R11";
        op(2'd2, 1, 9, 32'hA5A5_0001);
        cur_req = "R13";
        rd_lit(2'd2, 9, 32'hA5A5_0001);
        rd_lit(2'd1, FW - 1, 32'hFFFFFFFF);
        cur_req = "R8";
        op(2'd0, 1, 4, 32'd5);
        rd_lit(2'd0, 0, 32'd1);
        // R4 program without permission
        cur_req = "R4";
        op(2'd1, 1, 10, 32'h0);
        rd_lit(2'd1, 10, 32'hFFFFFFFF);
        // R3 bit-clearing program
        cur_req = "R3";
        op(2'd0, 1, 1, 32'd3);
        op(2'd1, 1, 10, 32'hF0F0_1234);
        op(2'd1, 1, 10, 32'hFF00_FFFF);
        rd_lit(2'd1, 10, 32'hF000_1234);
        op(2'd1, 1, 10, 32'hFFFF_FFFF);
        rd_lit(2'd1, 10, 32'hF000_1234);
        for (int k = 0; k < 4; k++) op(2'd1, 1, k * PW + 5, 32'h1234_0000 + k);
        op(2'd1, 1, PW - 1, 32'h0);
        op(2'd1, 1, 2 * PW, 32'h0);
        // R5 page erase through both registers, offset bits dropped
        cur_req = "R5";
        op(2'd0, 1, 2, 32'(PW * 4 + 32'h1C));
        rd_lit(2'd0, 0, 32'd0);
        wait_idle();
        rd_lit(2'd1, PW + 5, 32'hFFFFFFFF);
        rd_lit(2'd1, PW - 1, 32'h0);
        rd_lit(2'd1, 2 * PW, 32'h0);
        op(2'd0, 1, 3, 32'((FW - PW) * 4 + 3));
        wait_idle();
        rd_lit(2'd1, FW - PW + 5, 32'hFFFFFFFF);
        rd_lit(2'd1, 5, 32'h1234_0000);
        // R6 out-of-range page base
        cur_req = "R6";
        op(2'd1, 1, FW - 1, 32'h0);
        op(2'd0, 1, 2, 32'(FW * 4));
        rd_lit(2'd0, 0, 32'd1);
        rd_lit(2'd1, FW - 1, 32'h0);
        // R7 page erase without permission
        cur_req = "R7";
        op(2'd0, 1, 1, 32'd1);
        op(2'd0, 1, 2, 32'd0);
        rd_lit(2'd0, 0, 32'd1);
        rd_lit(2'd1, 5, 32'h1234_0000);
        cur_req = "R8";
        op(2'd0, 1, 4, 32'd1);
        rd_lit(2'd0, 0, 32'd1);
        // R9 user erase with no permission
        cur_req = "R9";
        op(2'd0, 1, 1, 32'd0);
        op(2'd2, 1, UW - 1, 32'h0BAD_F00D);
        op(2'd0, 1, 5, 32'd2);
        rd_lit(2'd2, UW - 1, 32'h0BAD_F00D);
        op(2'd0, 1, 5, 32'd1);
        rd_lit(2'd0, 0, 32'd0);
        wait_idle();
        rd_lit(2'd2, UW - 1, 32'hFFFFFFFF);
        rd_lit(2'd2, 9, 32'hFFFFFFFF);
        rd_lit(2'd1, 2 * PW, 32'h0);
        // R12 unmapped accesses
        cur_req = "R12";
        rd_lit(2'd0, 2, 32'd0);
        rd_lit(2'd0, 6, 32'd0);
        rd_lit(2'd3, 4, 32'd0);
        op(2'd0, 1, 0, 32'd0);
        op(2'd0, 1, 7, 32'd3);
        op(2'd3, 1, 1, 32'd3);
        rd_lit(2'd0, 1, 32'd0);
        rd_lit(2'd0, 0, 32'd1);
        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule